// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small tagged cache that the fetch stage consults with the current fetch address. Within the same cycle it reports whether that address is a known branch, whether the branch is expected to be taken, and the full predicted target. From these it forms the next fetch address. A hit with a taken prediction redirects fetch to the stored target with no stall. Every other case continues at the sequential address, which is the fetch address plus four.

The buffer is filled and repaired through a single update port. Decode uses that port to allocate an entry when it finds a branch that the buffer did not know about. Execute uses the same port to rewrite an entry when a prediction turns out wrong.

The block also reports the stall cost of each outcome, for verification. A fetch that needs no repair costs nothing. A missed branch found in decode costs one cycle. A misprediction found in execute costs two cycles.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is invalid: no fetch address hits, `pred_taken` is 0 and `next_pc` equals `fetch_pc + 4`.
- R2: When `fetch_pc` matches a valid entry whose taken bit is 1, `hit` and `pred_taken` are 1, `pred_target` is the stored target and `next_pc` equals that target in the same cycle (zero stall).
- R3: When `fetch_pc` matches a valid entry whose taken bit is 0, `hit` is 1, `pred_taken` is 0 and `next_pc` is `fetch_pc + 4`.
- R4: On a miss, `hit` and `pred_taken` are 0 and `next_pc` is `fetch_pc + 4`.
- R5: An allocation (`upd_valid`=1, `upd_fix`=0) writes a valid entry holding the tag, target and taken bit of `upd_pc`, visible from the next cycle. The penalty in that cycle is 1.
- R6: A correction (`upd_valid`=1, `upd_fix`=1) rewrites the entry of `upd_pc` with the given target and taken bit. The penalty in that cycle is 2.
- R7: With `upd_valid`=0 the penalty is 0 and no entry changes.
- R8: The slot index is `pc[7:2]` and the tag is `pc[31:8]` (64 slots, direct-mapped). An address with the same index but a different tag misses.
- R9: Writing to a slot replaces whatever entry the slot held before. The replaced address misses afterwards.
- R10: When an update and a lookup use the same slot in one cycle, the lookup sees the slot's contents from before the update.
- R11: Address bits 1:0 play no part in indexing or matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Fetch address being looked up |
| hit | output | 1 | Fetch address matches a valid entry |
| pred_taken | output | 1 | Hit and the entry predicts taken |
| pred_target | output | 32 | Stored target of the matching entry (0 on miss) |
| next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Update request this cycle |
| upd_fix | input | 1 | 0: allocation from decode, 1: correction from execute |
| upd_pc | input | 32 | Branch address being written |
| upd_target | input | 32 | Target address to store |
| upd_taken | input | 1 | Taken bit to store |
| penalty | output | 2 | Stall cycles of this cycle's outcome: 0, 1 or 2 |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and 64 slots. With these values the index boundaries (slot 0 and slot 63) and tag aliasing can be reached with a handful of hand-picked addresses. A pseudo-random sweep over a narrow address window then drives frequent replacement, and also drives update and lookup to the same slot in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    PEN_NONE      = 2'd0,
    PEN_MISFETCH  = 2'd1,
    PEN_MISPRED   = 2'd2
  } pen_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;
endpackage

// File: rtl/btb_addr.sv
module btb_addr #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::ALIGN_BITS
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  function automatic logic [IDX_W-1:0] slot_of(input logic [PC_W-1:0] a);
    return a[btb_pkg::ALIGN_BITS +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] a);
    return a[PC_W-1 -: TAG_W];
  endfunction

  logic [btb_pkg::ALIGN_BITS-1:0] unused_align;
  assign unused_align = pc[btb_pkg::ALIGN_BITS-1:0];

  assign idx = slot_of(pc);
  assign tag = tag_of(pc);
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = PC_W - IDX_W - btb_pkg::ALIGN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target,
  input  logic             wr_taken
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [PC_W-1:0]    target_q [ENTRIES];
  logic [ENTRIES-1:0] taken_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i]  <= 1'b0;
        tag_q[i]    <= '0;
        target_q[i] <= '0;
        taken_q[i]  <= 1'b0;
      end else if (sel) begin
        valid_q[i]  <= 1'b1;
        tag_q[i]    <= wr_tag;
        target_q[i] <= wr_target;
        taken_q[i]  <= wr_taken;
      end
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = target_q[rd_idx];
  assign rd_taken  = taken_q[rd_idx];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TAG_W = 24
) (
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PC_W-1:0]  ent_target,
  input  logic             ent_taken,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  target,
  output logic [PC_W-1:0]  next_pc
);
  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] a);
    return a + PC_W'(btb_pkg::INSN_BYTES);
  endfunction

  always_comb begin
    hit     = ent_valid && (ent_tag == fetch_tag);
    taken   = hit && ent_taken;
    target  = hit ? ent_target : '0;
    next_pc = taken ? ent_target : seq_pc(fetch_pc);
  end
endmodule

// File: rtl/btb_penalty.sv
module btb_penalty (
  input  logic            upd_valid,
  input  logic            upd_fix,
  output btb_pkg::pen_e   pen
);
  always_comb begin
    if (!upd_valid)   pen = btb_pkg::PEN_NONE;
    else if (upd_fix) pen = btb_pkg::PEN_MISPRED;
    else              pen = btb_pkg::PEN_MISFETCH;
  end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic [PC_W-1:0] next_pc,
  input  logic            upd_valid,
  input  logic            upd_fix,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken,
  output logic [1:0]      penalty
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::ALIGN_BITS;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             ent_valid, ent_taken;
  logic [TAG_W-1:0] ent_tag;
  logic [PC_W-1:0]  ent_target;
  logic             wr_fire;
  btb_pkg::pen_e    pen_cls;

  assign wr_fire = upd_valid;

  btb_addr #(.PC_W(PC_W), .IDX_W(IDX_W)) u_addr_fetch (
    .pc(fetch_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_addr #(.PC_W(PC_W), .IDX_W(IDX_W)) u_addr_upd (
    .pc(upd_pc), .idx(wr_idx), .tag(wr_tag)
  );

  btb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(ent_valid), .rd_tag(ent_tag),
    .rd_target(ent_target), .rd_taken(ent_taken),
    .wr_en(wr_fire), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_target(upd_target), .wr_taken(upd_taken)
  );

  btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_lookup (
    .fetch_pc(fetch_pc), .fetch_tag(lk_tag),
    .ent_valid(ent_valid), .ent_tag(ent_tag),
    .ent_target(ent_target), .ent_taken(ent_taken),
    .hit(hit), .taken(pred_taken), .target(pred_target), .next_pc(next_pc)
  );

  btb_penalty u_pen (
    .upd_valid(upd_valid), .upd_fix(upd_fix), .pen(pen_cls)
  );

  assign penalty = pen_cls;
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic [PC_W-1:0] next_pc,
  input logic            upd_valid,
  input logic            upd_fix,
  input logic [PC_W-1:0] upd_pc,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_taken,
  input logic [1:0]      penalty
);
  // R2: taken hit redirects to the stored target
  a_r2_taken_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pred_taken) |-> (next_pc == pred_target));

  // R3, R4: any non-taken outcome continues sequentially
  a_r4_seq_next: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (next_pc == fetch_pc + PC_W'(4)));

  a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> hit);

  // R5: allocation penalty
  a_r5_alloc_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_fix) |-> (penalty == 2'd1));

  // R6: correction penalty
  a_r6_fix_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_fix) |-> (penalty == 2'd2));

  // R7: no update, no penalty
  a_r7_idle_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (penalty == 2'd0));

  // R5, R6: a written entry is found by its own address in the next cycle
  a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ((fetch_pc != $past(upd_pc)) ||
                   (hit && pred_target == $past(upd_target) &&
                    pred_taken == $past(upd_taken))));
endmodule

bind btb_top btb_chk #(.PC_W(PC_W)) u_btb_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
  .pred_taken(pred_taken), .pred_target(pred_target), .next_pc(next_pc),
  .upd_valid(upd_valid), .upd_fix(upd_fix), .upd_pc(upd_pc),
  .upd_target(upd_target), .upd_taken(upd_taken), .penalty(penalty)
);

// File: tb/tb_btb_top.sv
`timescale 1ns/1ps
module tb_btb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, pred_taken;
  logic [31:0] pred_target, next_pc;
  logic        upd_valid = 1'b0, upd_fix = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;
  logic [1:0]  penalty;

  always #2.5 clk = ~clk;

  btb_top dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
    .pred_taken(pred_taken), .pred_target(pred_target), .next_pc(next_pc),
    .upd_valid(upd_valid), .upd_fix(upd_fix), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_taken(upd_taken), .penalty(penalty)
  );

  typedef struct {
    logic        hit;
    logic        tk;
    logic [31:0] tgt;
    logic [31:0] nxt;
    logic [1:0]  pen;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference contents, kept by address arithmetic of the bench's own
  bit          m_val [64];
  logic [23:0] m_tag [64];
  logic [31:0] m_tgt [64];
  bit          m_tk  [64];

  task automatic step(input logic [31:0] pc, input bit uv, input bit ufix,
                      input logic [31:0] upc, input logic [31:0] utgt,
                      input bit utk, input string req);
    exp_t e;
    int s, w;
    @(negedge clk);
    fetch_pc = pc; upd_valid = uv; upd_fix = ufix;
    upd_pc = upc; upd_target = utgt; upd_taken = utk;
    s = (pc / 4) % 64;
    e.hit = m_val[s] && (m_tag[s] == pc / 256);
    e.tk  = e.hit && m_tk[s];
    e.tgt = e.hit ? m_tgt[s] : 32'd0;
    e.nxt = e.tk ? m_tgt[s] : pc + 32'd4;
    e.pen = !uv ? 2'd0 : (ufix ? 2'd2 : 2'd1);
    e.req = req;
    exp_q.push_back(e);
    if (uv) begin   // R10: the write lands after this cycle's lookup
      w = (upc / 4) % 64;
      m_val[w] = 1; m_tag[w] = upc / 256; m_tgt[w] = utgt; m_tk[w] = utk;
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 0, 0, 32'd0, 32'd0, 0, req);
  endtask

  // monitor: compares one expected item per cycle, after outputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (hit !== e.hit || pred_taken !== e.tk || pred_target !== e.tgt ||
            next_pc !== e.nxt || penalty !== e.pen) begin
          errors++;
          $display("FAIL %s: got hit=%b tk=%b tgt=%h nxt=%h pen=%0d exp hit=%b tk=%b tgt=%h nxt=%h pen=%0d",
                   e.req, hit, pred_taken, pred_target, next_pc, penalty,
                   e.hit, e.tk, e.tgt, e.nxt, e.pen);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 64; i++) begin
      m_val[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_tk[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(32'h0000_0100, "R1");
    look(32'h0000_00FC, "R1");
    // R10 + R5: allocate and look up the same slot in one cycle
    step(32'h0000_0100, 1, 0, 32'h0000_0100, 32'h0000_0400, 1, "R10");
    look(32'h0000_0100, "R2");
    look(32'h0000_0103, "R11");
    step(32'h0000_0204, 1, 0, 32'h0000_0204, 32'h0000_0080, 0, "R5");
    look(32'h0000_0204, "R3");
    look(32'h0000_1100, "R8");
    look(32'h0000_0108, "R4");
    step(32'h0000_0300, 1, 1, 32'h0000_0100, 32'h0000_0500, 0, "R6");
    look(32'h0000_0100, "R6");
    look(32'h0000_0300, "R7");
    step(32'h0000_0100, 1, 0, 32'h0000_1100, 32'h0000_0040, 1, "R9");
    look(32'h0000_0100, "R9");
    look(32'h0000_1100, "R9");
    step(32'h0000_0000, 1, 0, 32'hABCD_00FC, 32'hFFFF_FFF0, 1, "R8");
    look(32'hABCD_00FC, "R8");
    look(32'h0000_00FC, "R8");
    lfsr = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a = {20'h0, lfsr[11:0]};
      b = {20'h0, lfsr[27:16]};
      step(a, lfsr[31], lfsr[30], (lfsr[29] ? a : b), lfsr ^ 32'h5A5A_0000,
           lfsr[28], "R5");
    end
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule